// File: doc/BRIEF.md
# Ethernet Receive Deframer

This block sits between a Manchester decoder and the receive buffer memory of an Ethernet station. It watches a serial NRZ bit stream qualified by a carrier/valid input. It discards everything up to and including the start-of-frame delimiter and then assembles the following bits into bytes. The first six bytes are the destination address. They are held back in a small byte ring until an address filter has judged them.

A frame that passes the filter is forwarded to a byte-wide output. The first byte carries a start marker and the last byte carries an end marker. A configuration bit chooses whether the four trailing check bytes go out with the frame or are stripped. A frame that fails the filter produces no output bytes.

When carrier drops, the block issues a one-cycle status strobe. The strobe reports the whole-byte length, a CRC verdict, undersize and oversize flags, an alignment flag and the accept decision. The CRC verdict comes from running CRC-32 over every received byte and comparing the register with the fixed residue. For an accepted frame, the strobe arrives in the same cycle as the end-marked byte.

Top module: `eth_rx_deframer`

## Requirements
- R1: While hunting, every input bit is ignored until the last eight bits seen with `rx_dv_i` high are 1,0,1,0,1,0,1,1 in arrival order. Every later bit is frame data, and bytes are assembled least significant bit first.
- R2: Each of three filter rules can be enabled on its own. `cfg_ucast_en_i` accepts a destination address equal to `station_addr_i`, where byte k of the frame is compared with `station_addr_i[8k+7:8k]`. `cfg_bcast_en_i` accepts the address FF:FF:FF:FF:FF:FF. `cfg_promisc_i` accepts any address. A frame shorter than six bytes is never accepted.
- R3: A rejected frame produces no `out_valid_o` pulse, and its status has `stat_accept_o` = 0.
- R4: An accepted frame is output in arrival order, one byte per `out_valid_o` pulse. `out_sof_o` is set only on the first output byte and `out_eof_o` only on the last.
- R5: If `cfg_keep_fcs_i` is 1 when the delimiter is found, every received byte is output. If it is 0, the final four bytes are withheld.
- R6: `stat_crc_err_o` is 1 exactly when the CRC-32 over all received whole bytes does not leave the residue 0xC704DD7B, which is 0xDEBB20E3 in bit-reversed register form.
- R7: `stat_runt_o` is 1 when the byte length is below MIN_LEN. `stat_long_o` is 1 when it is above MAX_LEN.
- R8: If carrier drops with 1 to 7 bits of an incomplete byte, `stat_align_o` is 1. Those bits are discarded and not counted.
- R9: Each frame gives exactly one single-cycle `stat_valid_o` pulse. `stat_len_o` is the number of whole bytes after the delimiter, check bytes included. For an accepted frame, the pulse coincides with the `out_eof_o` byte.
- R10: After reset, `out_valid_o`, `out_sof_o`, `out_eof_o` and `stat_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_dv_i | input | 1 | Carrier/valid; high while `rx_bit_i` carries a bit |
| rx_bit_i | input | 1 | Serial NRZ data |
| station_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| cfg_ucast_en_i | input | 1 | Enable exact station address match |
| cfg_bcast_en_i | input | 1 | Enable broadcast address match |
| cfg_promisc_i | input | 1 | Accept every address |
| cfg_keep_fcs_i | input | 1 | Forward the four check bytes |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | First byte of a frame |
| out_eof_o | output | 1 | Last byte of a frame |
| stat_valid_o | output | 1 | Status strobe, one per frame |
| stat_len_o | output | LEN_W (12) | Whole bytes received |
| stat_crc_err_o | output | 1 | CRC residue mismatch |
| stat_runt_o | output | 1 | Length below MIN_LEN |
| stat_long_o | output | 1 | Length above MAX_LEN |
| stat_align_o | output | 1 | Carrier dropped mid-byte |
| stat_accept_o | output | 1 | Frame passed the address filter |

## Verification
The bench builds the block with MIN_LEN = 20, MAX_LEN = 40 and BUF_DEPTH = 16. With these limits, frames on both sides of both size limits are only a few hundred bit cycles long. That brings the boundary lengths 19, 20, 40 and 41, plus oversize frames, within a short run alongside many random frames. The 16-entry ring still leaves ample margin above the ten bytes that can be held back while the filter decides and the check bytes are withheld.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  // delimiter in arrival order, oldest bit in the MSB
  localparam logic [7:0]  SFD_PATTERN    = 8'b1010_1011;
  localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB8_8320;
  // bit-reversed form of 0xC704DD7B
  localparam logic [31:0] CRC_RESIDUE    = 32'hDEBB_20E3;
  localparam int unsigned ADDR_BYTES     = 6;
  localparam int unsigned FCS_BYTES      = 4;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FLUSH = 2'd2
  } rx_state_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] data);
    logic [31:0] r;
    r = crc;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ data[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else                r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_rx_bit_aligner.sv
module eth_rx_bit_aligner
  import eth_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hunt_i,
  input  logic       data_en_i,
  input  logic       dv_i,
  input  logic       bit_i,
  output logic       sfd_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       partial_o
);

  logic [7:0] sh_q;
  logic [6:0] asm_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      asm_q <= '0;
      cnt_q <= '0;
    end else begin
      sh_q <= (hunt_i && dv_i) ? {sh_q[6:0], bit_i} : '0;
      if (data_en_i && dv_i) begin
        asm_q <= {bit_i, asm_q[6:1]};
        cnt_q <= cnt_q + 3'd1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign sfd_o      = hunt_i && dv_i && ({sh_q[6:0], bit_i} == SFD_PATTERN);
  assign byte_vld_o = data_en_i && dv_i && (cnt_q == 3'd7);
  assign byte_o     = {bit_i, asm_q};
  assign partial_o  = (cnt_q != 3'd0);

  // R1: the controller leaves the hunt state right after a delimiter
  assert_sfd_leaves_hunt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_o |=> !hunt_i);

endmodule

// File: rtl/eth_rx_crc_check.sv
module eth_rx_crc_check
  import eth_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       ok_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '1;
    else if (clr_i) crc_q <= '1;
    else if (vld_i) crc_q <= crc32_step(crc_q, byte_i);
  end

  assign ok_o = (crc_q == CRC_RESIDUE);

  // R6: register only moves on a byte or a restart
  assert_crc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !vld_i) |=> $stable(crc_q));

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        vld_i,
  input  logic [7:0]  byte_i,
  input  logic [47:0] station_i,
  input  logic        ucast_en_i,
  input  logic        bcast_en_i,
  input  logic        promisc_i,
  output logic        full_o,
  output logic        pass_o
);

  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]       cnt_q;
  logic [ADDR_BYTES*8-1:0] da_q;
  logic                   take;

  assign take = vld_i && (cnt_q < CNT_W'(ADDR_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (take)  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  da_q[g*8 +: 8] <= '0;
      else if (take && cnt_q == CNT_W'(g))          da_q[g*8 +: 8] <= byte_i;
    end
  end

  assign full_o = (cnt_q == CNT_W'(ADDR_BYTES));
  assign pass_o = full_o && (promisc_i
                          || (bcast_en_i && da_q == {(ADDR_BYTES*8){1'b1}})
                          || (ucast_en_i && da_q == station_i));

  // R2: address is frozen once complete, until the next frame restarts it
  assert_da_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clr_i) |=> $stable(da_q));

endmodule

// File: rtl/eth_rx_deframer.sv
module eth_rx_deframer
  import eth_rx_pkg::*;
#(
  parameter  int unsigned MIN_LEN   = 64,
  parameter  int unsigned MAX_LEN   = 1518,
  parameter  int unsigned BUF_DEPTH = 16,
  localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic             rx_bit_i,
  input  logic [47:0]      station_addr_i,
  input  logic             cfg_ucast_en_i,
  input  logic             cfg_bcast_en_i,
  input  logic             cfg_promisc_i,
  input  logic             cfg_keep_fcs_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_sof_o,
  output logic             out_eof_o,
  output logic             stat_valid_o,
  output logic [LEN_W-1:0] stat_len_o,
  output logic             stat_crc_err_o,
  output logic             stat_runt_o,
  output logic             stat_long_o,
  output logic             stat_align_o,
  output logic             stat_accept_o
);

  localparam int unsigned PTR_W = $clog2(BUF_DEPTH);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam logic [PTR_W:0]   STRIP_N = (PTR_W+1)'(FCS_BYTES);
  localparam logic [PTR_W:0]   DEPTH_N = (PTR_W+1)'(BUF_DEPTH);

  rx_state_e        st_q;
  logic [LEN_W-1:0] len_q;
  logic             dec_q, acc_q, keep_q, first_q, align_q;
  logic [PTR_W:0]   wr_q, rd_q, occ, strip;
  logic [7:0]       mem_q [BUF_DEPTH];

  logic       sfd, byte_vld, partial, crc_ok, filt_full, filt_pass;
  logic [7:0] rx_byte;
  logic       hunt, in_data, frame_end, acc_eff, wr_en, emit, last, reject_end, stat_fire;

  assign hunt    = (st_q == ST_HUNT);
  assign in_data = (st_q == ST_DATA);

  eth_rx_bit_aligner i_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hunt_i     (hunt),
    .data_en_i  (in_data),
    .dv_i       (rx_dv_i),
    .bit_i      (rx_bit_i),
    .sfd_o      (sfd),
    .byte_vld_o (byte_vld),
    .byte_o     (rx_byte),
    .partial_o  (partial)
  );

  eth_rx_crc_check i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sfd),
    .vld_i  (byte_vld),
    .byte_i (rx_byte),
    .ok_o   (crc_ok)
  );

  eth_rx_addr_filter i_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sfd),
    .vld_i      (byte_vld),
    .byte_i     (rx_byte),
    .station_i  (station_addr_i),
    .ucast_en_i (cfg_ucast_en_i),
    .bcast_en_i (cfg_bcast_en_i),
    .promisc_i  (cfg_promisc_i),
    .full_o     (filt_full),
    .pass_o     (filt_pass)
  );

  // withheld tail: check bytes when stripping, plus one byte to carry the end marker
  assign occ        = wr_q - rd_q;
  assign strip      = keep_q ? '0 : STRIP_N;
  assign acc_eff    = dec_q ? acc_q : filt_pass;
  assign frame_end  = in_data && !rx_dv_i;
  assign wr_en      = byte_vld && (!dec_q || acc_q);
  assign last       = (st_q == ST_FLUSH) && (occ == strip + 1'b1);
  assign emit       = (in_data && acc_eff && (occ > strip + 1'b1))
                   || ((st_q == ST_FLUSH) && (occ > strip));
  assign reject_end = frame_end && !acc_eff;
  assign stat_fire  = reject_end || last;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q[PTR_W-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      len_q   <= '0;
      dec_q   <= 1'b0;
      acc_q   <= 1'b0;
      keep_q  <= 1'b0;
      first_q <= 1'b0;
      align_q <= 1'b0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else begin
      if (emit) begin
        rd_q    <= rd_q + 1'b1;
        first_q <= 1'b0;
      end
      unique case (st_q)
        ST_HUNT: if (sfd) begin
          st_q    <= ST_DATA;
          len_q   <= '0;
          dec_q   <= 1'b0;
          acc_q   <= 1'b0;
          keep_q  <= cfg_keep_fcs_i;
          first_q <= 1'b1;
          wr_q    <= '0;
          rd_q    <= '0;
        end
        ST_DATA: begin
          if (byte_vld && len_q != '1) len_q <= len_q + 1'b1;
          if (!dec_q && filt_full) begin
            dec_q <= 1'b1;
            acc_q <= filt_pass;
          end
          if (wr_en) wr_q <= wr_q + 1'b1;
          if (frame_end) begin
            st_q    <= acc_eff ? ST_FLUSH : ST_HUNT;
            align_q <= partial;
          end
        end
        ST_FLUSH: if (last) st_q <= ST_HUNT;
        default:  st_q <= ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o    <= 1'b0;
      out_data_o     <= '0;
      out_sof_o      <= 1'b0;
      out_eof_o      <= 1'b0;
      stat_valid_o   <= 1'b0;
      stat_len_o     <= '0;
      stat_crc_err_o <= 1'b0;
      stat_runt_o    <= 1'b0;
      stat_long_o    <= 1'b0;
      stat_align_o   <= 1'b0;
      stat_accept_o  <= 1'b0;
    end else begin
      out_valid_o  <= emit;
      out_sof_o    <= emit && first_q;
      out_eof_o    <= last;
      if (emit) out_data_o <= mem_q[rd_q[PTR_W-1:0]];
      stat_valid_o <= stat_fire;
      if (stat_fire) begin
        stat_len_o     <= len_q;
        stat_crc_err_o <= !crc_ok;
        stat_runt_o    <= (len_q < MIN_L);
        stat_long_o    <= (len_q > MAX_L);
        stat_align_o   <= in_data ? partial : align_q;
        stat_accept_o  <= !reject_end;
      end
    end
  end

  assert_sof_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_valid_o);

  assert_eof_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eof_o |-> out_valid_o);

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= DEPTH_N);

  assert_reject_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && dec_q && !acc_q) |-> !out_valid_o);

  assert_stat_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);

  assert_stat_with_eof_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_accept_o) |-> out_eof_o);

endmodule

// File: tb/test_eth_rx_deframer.sv
module test_eth_rx_deframer;

  localparam int MIN_LEN   = 20;
  localparam int MAX_LEN   = 40;
  localparam int BUF_DEPTH = 16;
  localparam int LEN_W     = $clog2(MAX_LEN + 1) + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_dv_i = 1'b0;
  logic rx_bit_i = 1'b0;
  logic [47:0] station_addr_i = 48'h5A_34_12_CD_AB_02;
  logic cfg_ucast_en_i = 1'b1, cfg_bcast_en_i = 1'b1, cfg_promisc_i = 1'b0, cfg_keep_fcs_i = 1'b0;
  logic out_valid_o, out_sof_o, out_eof_o, stat_valid_o;
  logic [7:0] out_data_o;
  logic [LEN_W-1:0] stat_len_o;
  logic stat_crc_err_o, stat_runt_o, stat_long_o, stat_align_o, stat_accept_o;

  always #5 clk_i = ~clk_i;

  eth_rx_deframer #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .BUF_DEPTH(BUF_DEPTH)) i_eth_rx_deframer (
    .clk_i, .rst_ni, .rx_dv_i, .rx_bit_i, .station_addr_i,
    .cfg_ucast_en_i, .cfg_bcast_en_i, .cfg_promisc_i, .cfg_keep_fcs_i,
    .out_valid_o, .out_data_o, .out_sof_o, .out_eof_o,
    .stat_valid_o, .stat_len_o, .stat_crc_err_o, .stat_runt_o,
    .stat_long_o, .stat_align_o, .stat_accept_o
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [7:0] fr [0:63];
  logic [7:0] cap [0:127];
  int cap_n, sof_cnt, eof_cnt, sof_pos, eof_pos, stat_n;
  int s_len;
  bit s_crc, s_runt, s_long, s_align, s_acc, s_eof;

  always @(negedge clk_i) if (rst_ni) begin
    if (out_valid_o) begin
      if (cap_n < 128) cap[cap_n] = out_data_o;
      if (out_sof_o) begin sof_cnt++; sof_pos = cap_n; end
      if (out_eof_o) begin eof_cnt++; eof_pos = cap_n; end
      cap_n++;
    end
    if (stat_valid_o) begin
      stat_n++;
      s_len = int'(stat_len_o); s_crc = stat_crc_err_o; s_runt = stat_runt_o;
      s_long = stat_long_o; s_align = stat_align_o; s_acc = stat_accept_o; s_eof = out_eof_o;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fr[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return ~c;
  endfunction

  // kind: 0 station, 1 broadcast, 2 other
  task automatic build(input int len, input int kind, input bit bad);
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    if (len >= 10) begin
      for (int i = 0; i < 6; i++)
        fr[i] = (kind == 0) ? station_addr_i[i*8 +: 8] : (kind == 1) ? 8'hFF : 8'($urandom);
      if (kind == 2) begin fr[0][0] = 1'b0; fr[1] = ~station_addr_i[15:8]; end
      begin
        logic [31:0] f = ref_fcs(len - 4);
        for (int k = 0; k < 4; k++) fr[len-4+k] = f[k*8 +: 8];
      end
      if (bad) fr[6 + ($urandom % (len - 6))] ^= 8'h10;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    rx_dv_i = 1'b1;
    rx_bit_i = b;
  endtask

  task automatic send_frame(input int len, input int extra, input int noise);
    cap_n = 0; sof_cnt = 0; eof_cnt = 0; sof_pos = -1; eof_pos = -1; stat_n = 0;
    for (int i = 0; i < noise; i++) send_bit(i % 4 < 2);
    for (int i = 0; i < 56; i++) send_bit(i % 2 == 0);
    for (int i = 0; i < 8; i++) send_bit(8'b1010_1011 >> (7 - i));
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) send_bit(fr[i][b]);
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    @(negedge clk_i);
    rx_dv_i = 1'b0;
    repeat (30) @(negedge clk_i);
  endtask

  task automatic run_frame(input int len, input int kind, input bit bad, input int extra, input int noise);
    bit exp_acc, exp_err;
    int exp_out, mism;
    logic [47:0] da;
    build(len, kind, bad);
    send_frame(len, extra, noise);
    for (int i = 0; i < 6; i++) da[i*8 +: 8] = (i < len) ? fr[i] : 8'h00;
    exp_acc = (len >= 6) && (cfg_promisc_i || (cfg_bcast_en_i && da == 48'hFFFF_FFFF_FFFF)
                             || (cfg_ucast_en_i && da == station_addr_i));
    exp_err = (len < 4) ? 1'b1 : ({fr[len-1], fr[len-2], fr[len-3], fr[len-4]} != ref_fcs(len - 4));
    exp_out = exp_acc ? (cfg_keep_fcs_i ? len : len - 4) : 0;
    check_eq("R9", "status strobes", stat_n, 1);
    check_eq("R9", "status length", s_len, len);
    check_eq("R6", "crc error", int'(s_crc), int'(exp_err));
    check_eq("R7", "runt", int'(s_runt), int'(len < MIN_LEN));
    check_eq("R7", "oversize", int'(s_long), int'(len > MAX_LEN));
    check_eq("R8", "alignment", int'(s_align), int'(extra > 0));
    check_eq("R2", "accept", int'(s_acc), int'(exp_acc));
    if (exp_acc) check_eq("R5", "output count", cap_n, exp_out);
    else         check_eq("R3", "output count rejected", cap_n, 0);
    if (exp_acc) begin
      mism = 0;
      for (int i = 0; i < exp_out && i < cap_n; i++) if (cap[i] != fr[i]) mism++;
      check_eq("R4", "mismatched bytes (R1 order)", mism, 0);
      check_eq("R4", "sof count", sof_cnt, 1);
      check_eq("R4", "sof position", sof_pos, 0);
      check_eq("R4", "eof count", eof_cnt, 1);
      check_eq("R4", "eof position", eof_pos, exp_out - 1);
      check_eq("R9", "status with eof", int'(s_eof), 1);
    end
  endtask

  task automatic set_cfg(input bit u, input bit b, input bit p, input bit k);
    cfg_ucast_en_i = u; cfg_bcast_en_i = b; cfg_promisc_i = p; cfg_keep_fcs_i = k;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check_eq("R10", "out_valid in reset", int'(out_valid_o), 0);
    check_eq("R10", "stat_valid in reset", int'(stat_valid_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_eq("R10", "sof after reset", int'(out_sof_o), 0);
    check_eq("R10", "eof after reset", int'(out_eof_o), 0);

    set_cfg(1, 1, 0, 0); run_frame(30, 0, 0, 0, 0);   // unicast, stripped
    set_cfg(1, 1, 0, 1); run_frame(30, 0, 0, 0, 0);   // R5 keep check bytes
    set_cfg(1, 1, 0, 0); run_frame(25, 1, 0, 0, 0);   // broadcast
    set_cfg(1, 0, 0, 0); run_frame(25, 1, 0, 0, 0);   // R3 broadcast disabled
    set_cfg(0, 1, 0, 0); run_frame(25, 0, 0, 0, 0);   // R3 unicast disabled
    set_cfg(0, 0, 1, 0); run_frame(25, 2, 0, 0, 0);   // promiscuous
    set_cfg(1, 1, 0, 1); run_frame(25, 2, 0, 0, 0);   // R3 other address
    set_cfg(1, 1, 0, 1); run_frame(30, 0, 1, 0, 0);   // R6 corrupted
    set_cfg(1, 1, 0, 0); run_frame(12, 0, 0, 0, 0);   // R7 runt
    run_frame(19, 0, 0, 0, 0);
    run_frame(20, 0, 0, 0, 0);
    run_frame(40, 0, 0, 0, 0);
    run_frame(41, 0, 0, 0, 0);
    run_frame(48, 1, 0, 0, 0);
    run_frame(30, 0, 0, 3, 0);                         // R8 partial byte
    run_frame(30, 0, 0, 7, 0);
    run_frame(3, 0, 0, 0, 0);                          // too short to filter
    set_cfg(1, 1, 1, 1); run_frame(5, 0, 0, 5, 0);
    set_cfg(1, 1, 0, 0); run_frame(22, 0, 0, 0, 40);  // R1 noise before preamble

    for (int n = 0; n < 40; n++) begin
      set_cfg(1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom));
      run_frame(10 + int'($urandom % 39), int'($urandom % 3), ($urandom % 4) == 0,
                (($urandom % 5) == 0) ? 1 + int'($urandom % 7) : 0, int'($urandom % 2) * 12);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule